// File: doc/BRIEF.md
# SPI Master Serial Clock Divider

This block derives the serial shift clock of an SPI controller from the faster peripheral clock. Software loads a 7-bit rate code into a 16-bit control register. While the controller acts as master and the block is enabled, the block divides the peripheral clock by the code plus one. It also issues two single-cycle strobes for the companion shift register: one when the serial clock enters its active phase, one when it returns to idle.

Codes below three give the same quarter-rate clock as code three, so the serial clock never runs faster than a quarter of the peripheral clock. Odd divisors split the period unevenly, with one more cycle in the idle phase than in the active phase.

In slave mode the far end supplies the clock, so the block stops toggling and releases its output enable. A new rate code written while the clock runs is held back until the current period has ended.

Top module: `spi_baud_gen`

## Requirements
- R1: The control register keeps its rate code in bits 6..0. Bits 15..7 always read back as zero, and writing them has no effect on the read value.
- R2: After reset the register reads zero, `sclk_out` is at idle level 0 and no strobe is asserted.
- R3: For rate codes 3 to 127, the serial clock period is (code + 1) peripheral clock cycles.
- R4: Rate codes 0, 1 and 2 give a period of 4 peripheral clock cycles, the same as code 3.
- R5: Within a period of N cycles, `sclk_out` is high (active) for floor(N/2) cycles first and then low (idle) for ceil(N/2) cycles.
- R6: Each period carries exactly one `sample_stb` pulse, in the first active cycle, and exactly one `shift_stb` pulse, in the first idle cycle. The two never coincide.
- R7: With `master_mode` low, `sclk_oe` is 0, `sclk_out` stays idle and no strobes occur, whatever the rate code and `enable` are.
- R8: With `enable` low in master mode, `sclk_out` is idle, no strobes occur and the phase counter is cleared. In the cycle after `enable` is seen high, a fresh period starts, with `sample_stb` and an active `sclk_out`.
- R9: A rate code written while the clock runs leaves the current period unchanged. The new divisor applies from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wr_data | input | 16 | Write data for the control register |
| reg_rd_data | output | 16 | Control register read value |
| master_mode | input | 1 | 1 = block generates the clock, 0 = clock comes from outside |
| enable | input | 1 | Run request for the clock generator |
| sclk_out | output | 1 | Serial clock level |
| sclk_oe | output | 1 | Output enable for the serial clock pin |
| sample_stb | output | 1 | One-cycle pulse at the start of the active phase |
| shift_stb | output | 1 | One-cycle pulse at the start of the idle phase |

## Verification
The bench measures the active and idle phase lengths and counts the strobes of whole periods for even, odd and maximal divisors, and for the clamped codes 0 to 2. A divider that takes the code itself as the divisor, or that fails to clamp the low codes, shows the wrong period. A divider that rounds the odd half the other way shows swapped phase lengths.

A rate change is written in the middle of a period. A design that reloads its divisor immediately would cut that period short. The bench also toggles the mode and the enable: a design that keeps counting while disabled would restart in the middle of a phase, and one that ignores the mode would drive the pin in slave mode.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

   // Which half of the serial clock period the counter is in
   typedef enum logic {
      PH_ACTIVE = 1'b1,
      PH_IDLE   = 1'b0
   } sclk_phase_e;

   // Smallest divisor any configuration may produce (quarter rate)
   localparam int unsigned MIN_DIVISOR = 4;

endpackage

// File: rtl/spi_baud_reg.sv
module spi_baud_reg #(
   parameter int unsigned REG_W   = 16,
   parameter int unsigned FIELD_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   output logic [FIELD_W-1:0] field_o,
   output logic [REG_W-1:0]   rd_data
);

   localparam int unsigned PAD_W = REG_W - FIELD_W;

   logic [FIELD_W-1:0] field_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         field_q <= '0;
      else if (wr_en)
         field_q <= wr_data[FIELD_W-1:0];
   end

   assign field_o = field_q;

   generate
      if (PAD_W > 0) begin : g_padded
         assign rd_data = {{PAD_W{1'b0}}, field_q};
      end else begin : g_exact
         assign rd_data = field_q;
      end
   endgenerate

   // R1
   field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(field_q));

endmodule

// File: rtl/spi_baud_divsel.sv
module spi_baud_divsel #(
   parameter int unsigned FIELD_W   = 7,
   parameter int unsigned MIN_FIELD = 3,
   parameter int unsigned CNT_W     = 8
) (
   input  logic [FIELD_W-1:0] field_i,
   output logic [CNT_W-1:0]   div_o,
   output logic [CNT_W-1:0]   hi_o
);

   logic [FIELD_W-1:0] clamped;

   always_comb begin
      if (field_i < FIELD_W'(MIN_FIELD))
         clamped = FIELD_W'(MIN_FIELD);
      else
         clamped = field_i;
   end

   assign div_o = CNT_W'(clamped) + CNT_W'(1);
   // active phase takes the floor half; the idle phase gets the odd cycle
   assign hi_o  = div_o >> 1;

endmodule

// File: rtl/spi_baud_counter.sv
module spi_baud_counter
   import spi_baud_pkg::*;
#(
   parameter int unsigned CNT_W      = 8,
   parameter bit          IDLE_LEVEL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active_i,
   input  logic [CNT_W-1:0] div_i,
   input  logic [CNT_W-1:0] hi_i,
   output logic             sclk_o,
   output logic             lead_stb_o,
   output logic             trail_stb_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cur_div_q;
   logic [CNT_W-1:0] cur_hi_q;
   logic             run_q;
   logic             last_cyc;
   sclk_phase_e      phase;

   assign last_cyc = (cnt_q == (cur_div_q - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         cur_div_q <= CNT_W'(MIN_DIVISOR);
         cur_hi_q  <= CNT_W'(MIN_DIVISOR / 2);
         run_q     <= 1'b0;
      end else if (!active_i) begin
         cnt_q     <= '0;
         cur_div_q <= div_i;
         cur_hi_q  <= hi_i;
         run_q     <= 1'b0;
      end else if (!run_q) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (last_cyc) begin
         cnt_q     <= '0;
         cur_div_q <= div_i;
         cur_hi_q  <= hi_i;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign phase       = (run_q && (cnt_q < cur_hi_q)) ? PH_ACTIVE : PH_IDLE;
   assign lead_stb_o  = run_q && (cnt_q == '0);
   assign trail_stb_o = run_q && (cnt_q == cur_hi_q);

   generate
      if (IDLE_LEVEL) begin : g_idle_high
         assign sclk_o = (phase != PH_ACTIVE);
      end else begin : g_idle_low
         assign sclk_o = (phase == PH_ACTIVE);
      end
   endgenerate

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q < cur_div_q));

   // R6
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_stb_o && trail_stb_o));

   // R8
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> (cnt_q == '0) && !run_q);

   // R9
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && run_q && !last_cyc) |=> $stable(cur_div_q));

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
   parameter int unsigned REG_W      = 16,
   parameter int unsigned FIELD_W    = 7,
   parameter int unsigned MIN_FIELD  = 3,
   parameter bit          IDLE_LEVEL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic [15:0]      reg_wr_data,
   output logic [15:0]      reg_rd_data,
   input  logic             master_mode,
   input  logic             enable,
   output logic             sclk_out,
   output logic             sclk_oe,
   output logic             sample_stb,
   output logic             shift_stb
);

   localparam int unsigned CNT_W = $clog2((1 << FIELD_W) + 1);

   generate
      if (REG_W != 16) begin : g_bad_reg
         $error("spi_baud_gen: port width is fixed at 16 bits");
      end
      if (FIELD_W < 2 || FIELD_W > REG_W) begin : g_bad_field
         $error("spi_baud_gen: FIELD_W out of range");
      end
      if (MIN_FIELD < 3 || MIN_FIELD >= (1 << FIELD_W)) begin : g_bad_min
         $error("spi_baud_gen: MIN_FIELD must keep the divisor at 4 or more");
      end
   endgenerate

   logic [FIELD_W-1:0] field;
   logic [CNT_W-1:0]   div;
   logic [CNT_W-1:0]   hi_len;
   logic               active;

   spi_baud_reg #(.REG_W(REG_W), .FIELD_W(FIELD_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .wr_data (reg_wr_data),
      .field_o (field),
      .rd_data (reg_rd_data)
   );

   spi_baud_divsel #(.FIELD_W(FIELD_W), .MIN_FIELD(MIN_FIELD), .CNT_W(CNT_W)) u_divsel (
      .field_i (field),
      .div_o   (div),
      .hi_o    (hi_len)
   );

   assign active = master_mode && enable;

   spi_baud_counter #(.CNT_W(CNT_W), .IDLE_LEVEL(IDLE_LEVEL)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .active_i    (active),
      .div_i       (div),
      .hi_i        (hi_len),
      .sclk_o      (sclk_out),
      .lead_stb_o  (sample_stb),
      .trail_stb_o (shift_stb)
   );

   assign sclk_oe = master_mode;

   // R4
   low_code_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (field < FIELD_W'(MIN_FIELD)) |-> (div == CNT_W'(MIN_FIELD + 1)));

   // R7
   slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |=> (!master_mode || $rose(master_mode)) &&
                        !$past(sclk_oe) && !sample_stb && !shift_stb);

endmodule

// File: tb/spi_baud_gen_bench.sv
module spi_baud_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [15:0] reg_wr_data = '0;
   logic [15:0] reg_rd_data;
   logic        master_mode = 1'b0;
   logic        enable = 1'b0;
   logic        sclk_out;
   logic        sclk_oe;
   logic        sample_stb;
   logic        shift_stb;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #2 clk = ~clk;   // 250 MHz

   spi_baud_gen u_spi_baud_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_en   (reg_wr_en),
      .reg_wr_data (reg_wr_data),
      .reg_rd_data (reg_rd_data),
      .master_mode (master_mode),
      .enable      (enable),
      .sclk_out    (sclk_out),
      .sclk_oe     (sclk_oe),
      .sample_stb  (sample_stb),
      .shift_stb   (shift_stb)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         failures = failures + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [15:0] val);
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_wr_data = val;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   // Program a code with the divider stopped, then start it
   task automatic start_master(input logic [15:0] code);
      @(negedge clk);
      enable = 1'b0;
      master_mode = 1'b1;
      write_reg(code);
      @(negedge clk);
      enable = 1'b1;
   endtask

   task automatic wait_sample();
      int n = 0;
      @(negedge clk);
      while (!sample_stb && n < 1000) begin
         @(negedge clk);
         n++;
      end
   endtask

   // Called at a negedge where sample_stb is 1; returns at the next one
   task automatic count_period(input bit do_wr, input logic [15:0] wr_val,
                               output int hi, output int lo,
                               output int shifts, output int samples, output int order_err);
      int n = 0;
      bit seen_low = 1'b0;
      hi = 0; lo = 0; shifts = 0; samples = 0; order_err = 0;
      do begin
         if (do_wr && n == 1) begin
            reg_wr_en = 1'b1;
            reg_wr_data = wr_val;
         end else if (do_wr && n == 2) begin
            reg_wr_en = 1'b0;
         end
         if (sclk_out) begin
            hi++;
            if (seen_low) order_err++;
         end else begin
            if (!seen_low && !shift_stb) order_err++;
            seen_low = 1'b1;
            lo++;
         end
         if (shift_stb) shifts++;
         if (sample_stb) samples++;
         @(negedge clk);
         n++;
      end while (!sample_stb && n < 1000);
      reg_wr_en = 1'b0;
   endtask

   task automatic check_period(input logic [15:0] code, input int exp_n, input string req);
      int hi, lo, sh, sa, oe;
      start_master(code);
      wait_sample();
      count_period(1'b0, 16'h0, hi, lo, sh, sa, oe);
      check(hi + lo == exp_n, req, hi + lo, exp_n);
      check(hi == exp_n / 2, "R5 active length", hi, exp_n / 2);
      check(lo == exp_n - exp_n / 2, "R5 idle length", lo, exp_n - exp_n / 2);
      check(sh == 1 && sa == 1 && oe == 0, "R6 strobes", sh * 10 + sa + oe * 100, 11);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(reg_rd_data == 16'h0, "R2 register", reg_rd_data, 0);
      check(sclk_out == 1'b0, "R2 sclk", sclk_out, 0);
      check(!sample_stb && !shift_stb, "R2 strobes", sample_stb + shift_stb, 0);
   endtask

   task automatic t_register();
      write_reg(16'hFFFF);
      @(negedge clk);
      check(reg_rd_data == 16'h007F, "R1 reserved bits read zero", reg_rd_data, 16'h007F);
      write_reg(16'hAB05);
      @(negedge clk);
      check(reg_rd_data == 16'h0005, "R1 field only", reg_rd_data, 5);
   endtask

   task automatic t_divide();
      check_period(16'd3, 4, "R3 code 3");
      check_period(16'd4, 5, "R3 code 4");
      check_period(16'd9, 10, "R3 code 9");
      check_period(16'd126, 127, "R3 code 126");
      check_period(16'd127, 128, "R3 code 127");
   endtask

   task automatic t_clamp();
      check_period(16'd0, 4, "R4 code 0");
      check_period(16'd1, 4, "R4 code 1");
      check_period(16'd2, 4, "R4 code 2");
   endtask

   task automatic t_slave();
      int bad = 0;
      @(negedge clk);
      master_mode = 1'b0;
      enable = 1'b1;
      write_reg(16'd5);
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (sclk_oe || sclk_out || sample_stb || shift_stb) bad++;
      end
      check(bad == 0, "R7 slave quiet", bad, 0);
      check(reg_rd_data == 16'd5, "R7 code kept", reg_rd_data, 5);
   endtask

   task automatic t_disable();
      int bad = 0;
      start_master(16'd7);
      repeat (13) @(negedge clk);
      enable = 1'b0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (sclk_out || sample_stb || shift_stb || !sclk_oe) bad++;
      end
      check(bad == 0, "R8 disabled quiet", bad, 0);
      enable = 1'b1;
      @(negedge clk);
      check(sample_stb && sclk_out, "R8 fresh period", {sample_stb, sclk_out}, 3);
   endtask

   task automatic t_rate_change();
      int hi, lo, sh, sa, oe;
      start_master(16'd9);
      wait_sample();
      count_period(1'b1, 16'd3, hi, lo, sh, sa, oe);
      check(hi == 5 && lo == 5, "R9 current period kept", hi + lo, 10);
      count_period(1'b0, 16'h0, hi, lo, sh, sa, oe);
      check(hi + lo == 4, "R9 new divisor next period", hi + lo, 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_register();
      t_divide();
      t_clamp();
      t_slave();
      t_disable();
      t_rate_change();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule